// File: doc/BRIEF.md
# Unit-to-Unit Dependency Matrix

This block keeps the ordering between in-flight function units as a square grid of single-bit cells, one row and one column per unit. A set cell in row i, column j means unit i must wait for unit j. Two separate bit planes are held. The read plane records units whose results unit i still has to read. The write plane records units that must read their operands before unit i may overwrite a register. Taken together, the cells form a directed acyclic graph that preserves program order without any sequence numbers. The row index is the unit's own identity, so no tag is stored and no associative lookup is made.

When a unit issues, the issue logic raises a strobe, selects the unit with a one-hot vector and presents two dependency vectors. These vectors are loaded into that unit's row in both planes. When units finish, a one-hot (or multi-hot) completion vector clears their columns in every row. For each row, a wide NOR of the read plane gives a "may read" flag, and a NOR of the write plane gives a "may write" flag. The register-tracking side of the scoreboard lies outside this block.

Top module: `unit_dep_matrix`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, every cell in both planes is cleared. In the first cycle after reset, all `may_read` and `may_write` bits are 1.
- R2: When `issue_valid` is high and `issue_unit` selects unit u, the read-plane row of unit u is replaced by `raw_deps`, one clock later. Bit u of `may_read` is 0 while any of those bits stays set.
- R3: The write plane is loaded from `war_deps` and drives `may_write` in the same way, independently of the read plane.
- R4: Setting bit j of `done_units` clears column j in every row of both planes on the next edge. A row's ready flag returns to 1 only when its last dependency bit has been cleared.
- R5: A unit never depends on itself. A bit u in `raw_deps` or `war_deps` while unit u issues has no effect.
- R6: If unit j completes in the same cycle that another unit issues with a dependency on j, the clear wins and the issuing row does not keep bit j.
- R7: An issue leaves every other row unchanged, apart from clears caused by completions in the same cycle.
- R8: While `issue_valid` is low, `issue_unit`, `raw_deps` and `war_deps` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue strobe |
| issue_unit | input | N_UNITS | One-hot index of the issuing unit |
| raw_deps | input | N_UNITS | Units whose results the issuing unit must wait for |
| war_deps | input | N_UNITS | Units that must read before the issuing unit writes |
| done_units | input | N_UNITS | Units completing this cycle |
| may_read | output | N_UNITS | Per unit: no read-plane dependency left |
| may_write | output | N_UNITS | Per unit: no write-plane dependency left |

## Verification
The two functions that can fall in the same cycle are a row load at issue and a column clear at completion. The bench provokes this by issuing a unit whose dependency vector names a unit completing on the same edge, once in each plane. It also completes one unit while another unrelated unit issues. A reference model in the bench applies the clear after the load and predicts both ready vectors. The bench then judges the design by whether the issuing row reads as ready and whether the other rows lost only the completed column.

// File: rtl/unit_dep_pkg.sv
// Package: shared helpers for the unit dependency matrix.
// Assumes no configuration has more than MAX_UNITS units.
package unit_dep_pkg;
    localparam int MAX_UNITS = 64;

    // True when no bit of the zero-extended vector is set (wide NOR).
    function automatic logic all_clear(input logic [MAX_UNITS-1:0] v);
        return (v == '0);
    endfunction
endpackage

// File: rtl/dep_row.sv
// Module: dep_row
// One row of one bit plane. It holds the dependencies of unit ROW on
// other units. A load replaces the row; clears drop columns and take
// priority over the load. The diagonal cell is always zero.
// Assumes ROW < N_UNITS <= MAX_UNITS.
module dep_row #(
    parameter int N_UNITS = 8,
    parameter int ROW     = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [N_UNITS-1:0] load_bits,
    input  logic [N_UNITS-1:0] clr_cols,
    output logic [N_UNITS-1:0] row_q,
    output logic               ready
);
    import unit_dep_pkg::*;

    localparam logic [N_UNITS-1:0] SELF_MASK = N_UNITS'(1) << ROW;

    // Row register: reset, load with clears applied, or clear only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (load)
            row_q <= load_bits & ~clr_cols & ~SELF_MASK;
        else
            row_q <= row_q & ~clr_cols;
    end

    // Readiness: wide NOR across the row.
    always_comb ready = all_clear(MAX_UNITS'(row_q));
endmodule

// File: rtl/dep_plane.sv
// Module: dep_plane
// One square bit plane: a dep_row per unit. The issuing unit's row is
// loaded; the completion vector clears columns in every row.
// Assumes issue_unit is one-hot or zero.
module dep_plane #(
    parameter int N_UNITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_valid,
    input  logic [N_UNITS-1:0]         issue_unit,
    input  logic [N_UNITS-1:0]         dep_bits,
    input  logic [N_UNITS-1:0]         done_units,
    output logic [N_UNITS*N_UNITS-1:0] rows_flat,
    output logic [N_UNITS-1:0]         ready
);
    localparam int CELLS = N_UNITS * N_UNITS;

    logic [N_UNITS-1:0] row_load;

    // Per-row load strobe from the one-hot issue selector.
    always_comb row_load = issue_unit & {N_UNITS{issue_valid}};

    for (genvar r = 0; r < N_UNITS; r++) begin : g_row
        dep_row #(
            .N_UNITS (N_UNITS),
            .ROW     (r)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (row_load[r]),
            .load_bits (dep_bits),
            .clr_cols  (done_units),
            .row_q     (rows_flat[r*N_UNITS +: N_UNITS]),
            .ready     (ready[r])
        );
    end

    if (CELLS > unit_dep_pkg::MAX_UNITS * unit_dep_pkg::MAX_UNITS) begin : g_size_err
        $error("dep_plane: too many units");
    end
endmodule

// File: rtl/unit_dep_matrix.sv
// Module: unit_dep_matrix (top)
// Unit-to-unit dependency matrix with a read-hazard plane and a
// write-hazard plane. It gives per-unit may_read / may_write flags.
// Assumes issue_unit is one-hot or zero; reset is synchronous active-low.
module unit_dep_matrix #(
    parameter int N_UNITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [N_UNITS-1:0] issue_unit,
    input  logic [N_UNITS-1:0] raw_deps,
    input  logic [N_UNITS-1:0] war_deps,
    input  logic [N_UNITS-1:0] done_units,
    output logic [N_UNITS-1:0] may_read,
    output logic [N_UNITS-1:0] may_write
);
    localparam int CELLS = N_UNITS * N_UNITS;

    logic [CELLS-1:0] raw_cells;
    logic [CELLS-1:0] war_cells;

    // Read plane: waits for producers' results.
    dep_plane #(.N_UNITS(N_UNITS)) u_raw (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_unit  (issue_unit),
        .dep_bits    (raw_deps),
        .done_units  (done_units),
        .rows_flat   (raw_cells),
        .ready       (may_read)
    );

    // Write plane: waits for earlier readers before overwriting.
    dep_plane #(.N_UNITS(N_UNITS)) u_war (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_unit  (issue_unit),
        .dep_bits    (war_deps),
        .done_units  (done_units),
        .rows_flat   (war_cells),
        .ready       (may_write)
    );
endmodule

// Checker: temporal properties of the dependency matrix.
module unit_dep_matrix_chk #(
    parameter int N_UNITS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       issue_valid,
    input logic [N_UNITS-1:0]         issue_unit,
    input logic [N_UNITS-1:0]         raw_deps,
    input logic [N_UNITS-1:0]         war_deps,
    input logic [N_UNITS-1:0]         done_units,
    input logic [N_UNITS-1:0]         may_read,
    input logic [N_UNITS-1:0]         may_write,
    input logic [N_UNITS*N_UNITS-1:0] raw_cells,
    input logic [N_UNITS*N_UNITS-1:0] war_cells
);
    // R1: first cycle out of reset shows every unit ready.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&may_read && &may_write));

    // Input assumption: at most one issuing unit.
    p_issue_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> $onehot0(issue_unit));

    // R8: no issue and no completion leaves both planes unchanged.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(issue_valid) && $past(done_units) == '0)
        |-> ($stable(raw_cells) && $stable(war_cells)));

    for (genvar i = 0; i < N_UNITS; i++) begin : g_chk
        // R4, R6: a completed column is empty in every row afterwards.
        p_col_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |->
            ((raw_cells[i*N_UNITS +: N_UNITS] & $past(done_units)) == '0 &&
             (war_cells[i*N_UNITS +: N_UNITS] & $past(done_units)) == '0));

        // R2, R3: the issuing row holds only bits from its own dependency vectors.
        p_issue_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(issue_valid) && $past(issue_unit[i])) |->
            ((raw_cells[i*N_UNITS +: N_UNITS] & ~$past(raw_deps)) == '0 &&
             (war_cells[i*N_UNITS +: N_UNITS] & ~$past(war_deps)) == '0));

        // R7: rows not issuing never gain bits.
        p_other_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !($past(issue_valid) && $past(issue_unit[i]))) |->
            ((raw_cells[i*N_UNITS +: N_UNITS] &
              ~$past(raw_cells[i*N_UNITS +: N_UNITS])) == '0 &&
             (war_cells[i*N_UNITS +: N_UNITS] &
              ~$past(war_cells[i*N_UNITS +: N_UNITS])) == '0));
    end
endmodule

bind unit_dep_matrix unit_dep_matrix_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_unit  (issue_unit),
    .raw_deps    (raw_deps),
    .war_deps    (war_deps),
    .done_units  (done_units),
    .may_read    (may_read),
    .may_write   (may_write),
    .raw_cells   (raw_cells),
    .war_cells   (war_cells)
);

// File: tb/sim_unit_dep_matrix.sv
// Bench: a driver task predicts ready vectors into a queue, and a monitor
// pops and compares them 5 ns after each rising edge.
module sim_unit_dep_matrix;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [N-1:0] issue_unit = '0;
    logic [N-1:0] raw_deps = '0;
    logic [N-1:0] war_deps = '0;
    logic [N-1:0] done_units = '0;
    logic [N-1:0] may_read;
    logic [N-1:0] may_write;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] raw_m [N];
    logic [N-1:0] war_m [N];
    logic [2*N-1:0] exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;  // 50 MHz

    unit_dep_matrix #(.N_UNITS(N)) u0 (
        .clk, .rst_n, .issue_valid, .issue_unit, .raw_deps,
        .war_deps, .done_units, .may_read, .may_write
    );

    // Drive one cycle of stimulus, update the reference and queue the prediction.
    task automatic step(input logic rst, input logic v, input logic [N-1:0] u,
                        input logic [N-1:0] rd, input logic [N-1:0] wd,
                        input logic [N-1:0] dn, input string tag);
        logic [2*N-1:0] e;
        @(negedge clk);
        rst_n = rst; issue_valid = v; issue_unit = u;
        raw_deps = rd; war_deps = wd; done_units = dn;
        for (int r = 0; r < N; r++) begin
            if (!rst) begin
                raw_m[r] = '0; war_m[r] = '0;
            end else if (v && u[r]) begin
                raw_m[r] = rd & ~dn & ~(N'(1) << r);
                war_m[r] = wd & ~dn & ~(N'(1) << r);
            end else begin
                raw_m[r] = raw_m[r] & ~dn;
                war_m[r] = war_m[r] & ~dn;
            end
            e[r]     = (raw_m[r] == '0);
            e[N + r] = (war_m[r] == '0);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each prediction after the edge that should produce it.
    always begin
        @(posedge clk);
        #5;
        if (exp_q.size() > 0) begin
            logic [2*N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({may_write, may_read} !== e) begin
                bad++;
                $display("FAIL %s: actual wr=%b rd=%b expected wr=%b rd=%b",
                         t, may_write, may_read, e[2*N-1:N], e[N-1:0]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < N; r++) begin raw_m[r] = '0; war_m[r] = '0; end
        repeat (3) @(negedge clk);
        step(1'b1, 1'b0, '0, '0, '0, '0, "R1 reset state");
        // R2/R3: unit 2 waits on units 0,1 to read and on unit 4 to write.
        step(1'b1, 1'b1, 8'h04, 8'h03, 8'h10, '0, "R2 R3 issue unit2");
        // R2/R7: unit 5 waits on unit 2; row 2 untouched.
        step(1'b1, 1'b1, 8'h20, 8'h04, 8'h00, '0, "R2 R7 issue unit5");
        // R8: junk dependencies with strobe low.
        step(1'b1, 1'b0, 8'h01, 8'hFF, 8'hFF, '0, "R8 strobe low ignored");
        // R4: partial completion keeps unit 2 blocked.
        step(1'b1, 1'b0, '0, '0, '0, 8'h01, "R4 partial clear");
        step(1'b1, 1'b0, '0, '0, '0, 8'h02, "R4 last dependency cleared");
        // R5: self-dependency has no effect.
        step(1'b1, 1'b1, 8'h08, 8'h08, 8'h08, '0, "R5 self bit ignored");
        // R6: unit 6 depends on 2 and 4; unit 4 completes the same cycle.
        step(1'b1, 1'b1, 8'h40, 8'h14, 8'h00, 8'h10, "R6 clear beats load raw");
        step(1'b1, 1'b0, '0, '0, '0, 8'h04, "R4 column clear frees two rows");
        // R6 on write plane, plus R7: unit 7 issues while unit 6 completes.
        step(1'b1, 1'b1, 8'h80, 8'h00, 8'h40, 8'h40, "R6 clear beats load war");
        step(1'b1, 1'b1, 8'h01, 8'h80, 8'h82, '0, "R3 R7 issue unit0");
        step(1'b1, 1'b0, '0, '0, '0, 8'h02, "R3 write plane partial clear");
        step(1'b1, 1'b0, '0, '0, '0, 8'h80, "R4 multi-plane clear");
        step(1'b1, 1'b1, 8'h10, 8'hEF, 8'hEF, '0, "R2 R3 wide dependency");
        step(1'b0, 1'b0, '0, '0, '0, '0, "R1 reset mid-run");
        step(1'b1, 1'b0, '0, '0, '0, '0, "R1 after reset");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule